// File: doc/BRIEF.md
# Receive Queue with Trigger Level and Character Timeout

This block is the receive-side character queue of a 16550-style serial port. The receive shifter hands it one character at a time, together with three per-character tags: parity error, framing error and break. The queue holds up to sixteen such entries in arrival order. Reads of the receive buffer register pop the oldest entry. The head entry's byte is always visible on `rd_data`.

From its contents the block derives several results:
- a data-ready flag;
- a trigger flag, raised when the fill level reaches a threshold that the FIFO-control write picks;
- a sticky overrun flag, raised when a character arrives with no free slot;
- the head entry's three error tags, hidden once a line-status read has seen them;
- a summary error flag, set while any stored entry is tagged;
- a character-timeout flag.

The timeout flag rises after a fixed number of character-time ticks pass with data waiting and no push or pop.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty (`level` 0, `data_ready` 0), the trigger threshold is 1 character, and `trig_hit`, `overrun`, `err_any`, `timeout` and the three head tag outputs are all 0.
- R2: Characters are returned in arrival order. `rd_data` shows the oldest stored byte, and each pop advances to the next one.
- R3: Bits 7:6 of a FIFO-control write set the trigger threshold: 00 is 1, 01 is 4, 10 is 8 and 11 is 14 characters. `trig_hit` is 1 exactly while `level` is at or above that threshold.
- R4: A FIFO-control write with bit 1 set empties the queue, so `level`, `err_any` and `timeout` go to 0. A write with bit 1 clear (for example 0x01 or 0x41) leaves the contents untouched.
- R5: A push while the queue holds 16 entries and no pop is present is dropped. It sets `overrun`, and the stored entries stay intact and readable in order. `overrun` stays set until a line-status read, which clears it.
- R6: A pop while the queue is empty has no effect: `level` stays 0 and a later push is stored normally.
- R7: `head_perr`, `head_ferr` and `head_brk` show the tags of the head entry. After a line-status read they read 0 until the head entry changes.
- R8: `err_any` is 1 exactly while at least one stored entry carries any of the three tags.
- R9: `timeout` rises after 4 `char_tick` pulses with the queue non-empty and no push or pop. Any push or pop restarts the count, and the flag never rises while the queue is empty.
- R10: Popping the last pending character after a timeout leaves `data_ready` and `timeout` both 0.
- R11: A push and a pop in the same cycle on a full queue store the new character, keep `level` at 16 and do not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Character strobe from the receive shifter |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity-error tag of the received byte |
| push_ferr | input | 1 | Framing-error tag of the received byte |
| push_brk | input | 1 | Break tag of the received byte |
| pop | input | 1 | Receive-buffer read strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| fcr_we | input | 1 | FIFO-control write strobe |
| fcr_data | input | 8 | FIFO-control write data (bit 1: clear, bits 7:6: trigger) |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Head byte (0 when empty) |
| level | output | 5 | Number of stored entries |
| data_ready | output | 1 | Queue non-empty |
| trig_hit | output | 1 | Level at or above the trigger threshold |
| overrun | output | 1 | Sticky overrun flag |
| head_perr | output | 1 | Head entry parity tag (unseen) |
| head_ferr | output | 1 | Head entry framing tag (unseen) |
| head_brk | output | 1 | Head entry break tag (unseen) |
| err_any | output | 1 | Some stored entry is tagged |
| timeout | output | 1 | Character timeout |

## Verification
Every result is held in a register that captures the strobe at a rising edge, and the outputs decode those registers directly. So a push, pop, line-status read, control write or tick shows its effect exactly one cycle later. The bench drives each strobe for one cycle just after a rising edge and samples 1 ns after the next rising edge. Timeout is counted tick by tick: the bench checks that the flag is still low after the third quiet tick and high after the fourth.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic [RXQ_DW-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rxq_entry_t;

  // threshold decode of the two trigger-select bits
  function automatic int unsigned trig_threshold(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic       clr,
  input  rxq_entry_t wr_entry,
  output rxq_entry_t head,
  output logic [CW-1:0] count,
  output logic       empty,
  output logic       full,
  output logic       push_ok,
  output logic       pop_ok,
  output logic       ovf
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] rptr, rptr_n, wptr, wptr_n;
  logic [CW-1:0] count_n;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push & ~clr & (~full | pop);
  assign pop_ok  = pop & ~clr & ~empty;
  assign ovf     = push & ~clr & full & ~pop;
  assign head    = empty ? '0 : mem[rptr];

  always_comb begin
    rptr_n  = rptr;
    wptr_n  = wptr;
    count_n = count;
    if (clr) begin
      rptr_n  = '0;
      wptr_n  = '0;
      count_n = '0;
    end else begin
      if (push_ok) wptr_n = ptr_inc(wptr);
      if (pop_ok)  rptr_n = ptr_inc(rptr);
      count_n = count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      rptr  <= rptr_n;
      wptr  <= wptr_n;
      count <= count_n;
    end
  end

  // storage array: written only on an accepted push, no reset needed
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_entry;
  end

  // R6: a pop on an empty queue leaves it empty
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);
  // R5: a dropped push keeps the queue full
  a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> full);
  // R11: simultaneous push and pop on a full queue stays full
  a_r11_swap_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !clr) |=> full);
  // R4: clear empties the queue
  a_r4_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic wr_tagged,
  input  logic pop_ok,
  input  logic head_tagged,
  input  logic h_perr,
  input  logic h_ferr,
  input  logic h_brk,
  input  logic ovf,
  input  logic lsr_rd,
  input  logic clr,
  input  logic empty,
  output logic overrun,
  output logic head_perr,
  output logic head_ferr,
  output logic head_brk,
  output logic err_any
);
  logic [CW-1:0] err_cnt, err_cnt_n;
  logic          seen, seen_n;
  logic          overrun_n;

  always_comb begin
    // tagged-entry population
    if (clr) err_cnt_n = '0;
    else     err_cnt_n = err_cnt + CW'(push_ok & wr_tagged) - CW'(pop_ok & head_tagged);
    // tag visibility mask: reset whenever the head changes
    if (clr || pop_ok || empty) seen_n = 1'b0;
    else if (lsr_rd)            seen_n = 1'b1;
    else                        seen_n = seen;
    // sticky overrun, set beats clear
    if (ovf)         overrun_n = 1'b1;
    else if (lsr_rd) overrun_n = 1'b0;
    else             overrun_n = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      seen    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      err_cnt <= err_cnt_n;
      seen    <= seen_n;
      overrun <= overrun_n;
    end
  end

  assign err_any   = (err_cnt != '0);
  assign head_perr = h_perr & ~seen;
  assign head_ferr = h_ferr & ~seen;
  assign head_brk  = h_brk & ~seen;

  // R8: a tagged entry can only exist while the queue holds data
  a_r8_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> !empty);
  // R5: a dropped push raises overrun
  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> overrun);
  // R7: a status read hides the head tags while the head stays
  a_r7_tags_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !empty && !pop_ok && !clr) |=> !(head_perr || head_ferr || head_brk));
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TMO_CHARS = 4,
  localparam int TW = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic activity,
  input  logic empty,
  output logic timeout
);
  logic [TW-1:0] cnt, cnt_n;

  always_comb begin
    if (activity || empty)                 cnt_n = '0;
    else if (tick && cnt != TW'(TMO_CHARS)) cnt_n = cnt + TW'(1);
    else                                   cnt_n = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign timeout = (cnt == TW'(TMO_CHARS));

  // R9: no timeout with an empty queue
  a_r9_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !empty);
  // R10: any push or pop drops the timeout on the next cycle
  a_r10_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !timeout);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [RXQ_DW-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop,
  input  logic              lsr_rd,
  input  logic              fcr_we,
  input  logic [7:0]        fcr_data,
  input  logic              char_tick,
  output logic [RXQ_DW-1:0] rd_data,
  output logic [CW-1:0]     level,
  output logic              data_ready,
  output logic              trig_hit,
  output logic              overrun,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic              err_any,
  output logic              timeout
);
  rxq_entry_t wr_entry, head;
  logic       empty, full, push_ok, pop_ok, ovf, clr;
  logic [1:0] trig_sel, trig_sel_n;
  logic       unused_fcr;

  assign clr        = fcr_we & fcr_data[1];
  assign unused_fcr = ^{fcr_data[5:2], fcr_data[0]};
  assign wr_entry   = '{data: push_data, perr: push_perr, ferr: push_ferr, brk: push_brk};

  always_comb begin
    trig_sel_n = fcr_we ? fcr_data[7:6] : trig_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_sel <= 2'b00;
    else        trig_sel <= trig_sel_n;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .pop(pop), .clr(clr),
    .wr_entry(wr_entry), .head(head), .count(level), .empty(empty), .full(full),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf(ovf)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok),
    .wr_tagged(push_perr | push_ferr | push_brk), .pop_ok(pop_ok),
    .head_tagged(head.perr | head.ferr | head.brk),
    .h_perr(head.perr), .h_ferr(head.ferr), .h_brk(head.brk),
    .ovf(ovf), .lsr_rd(lsr_rd), .clr(clr), .empty(empty),
    .overrun(overrun), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .err_any(err_any)
  );

  rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(char_tick),
    .activity(push_valid | pop | clr), .empty(empty), .timeout(timeout)
  );

  assign rd_data    = head.data;
  assign data_ready = ~empty;
  assign trig_hit   = (level >= CW'(trig_threshold(trig_sel)));

  // R3: the smallest threshold is one character, so data always trips level 1 mode
  a_r3_trig_one: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'b00 && data_ready) |-> trig_hit);
  // R3: no trigger without data
  a_r3_trig_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_valid, push_perr, push_ferr, push_brk;
  logic [7:0] push_data;
  logic       pop, lsr_rd, fcr_we, char_tick;
  logic [7:0] fcr_data;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       data_ready, trig_hit, overrun, head_perr, head_ferr, head_brk, err_any, timeout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxq_top u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .pop(pop), .lsr_rd(lsr_rd), .fcr_we(fcr_we), .fcr_data(fcr_data),
    .char_tick(char_tick), .rd_data(rd_data), .level(level),
    .data_ready(data_ready), .trig_hit(trig_hit), .overrun(overrun),
    .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
    .err_any(err_any), .timeout(timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push1(input logic [7:0] d, input logic pe = 0, input logic fe = 0,
                       input logic bk = 0);
    push_valid = 1; push_data = d; push_perr = pe; push_ferr = fe; push_brk = bk;
    cyc();
    push_valid = 0; push_perr = 0; push_ferr = 0; push_brk = 0;
  endtask

  task automatic pop1();
    pop = 1; cyc(); pop = 0;
  endtask

  task automatic lsr1();
    lsr_rd = 1; cyc(); lsr_rd = 0;
  endtask

  task automatic fcr1(input logic [7:0] d);
    fcr_we = 1; fcr_data = d; cyc(); fcr_we = 0;
  endtask

  task automatic tick1();
    char_tick = 1; cyc(); char_tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 trig_hit", trig_hit, 0);
    chk("R1 flags", {overrun, err_any, timeout, head_perr, head_ferr, head_brk}, 0);
    push1(8'h5A);
    chk("R1 default threshold 1", trig_hit, 1);
    fcr1(8'h02);
  endtask

  task automatic t_order();
    push1(8'hA1); push1(8'hB2); push1(8'hC3);
    chk("R2 level", level, 3);
    chk("R2 head first", rd_data, 8'hA1);
    pop1();
    chk("R2 head second", rd_data, 8'hB2);
    pop1();
    chk("R2 head third", rd_data, 8'hC3);
    pop1();
    chk("R2 drained", data_ready, 0);
  endtask

  task automatic t_trigger();
    int thr [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      fcr1({s[1:0], 6'b000010});
      for (int i = 0; i < thr[s] - 1; i++) push1(8'(i));
      chk("R3 below threshold", trig_hit, 0);
      push1(8'hFF);
      chk("R3 at threshold", trig_hit, 1);
    end
    fcr1(8'h41);
    chk("R4 no-clear write keeps level", level, 14);
    chk("R3 threshold 4 reselected", trig_hit, 1);
    fcr1(8'h02);
    chk("R4 clear empties", level, 0);
    chk("R4 clear data_ready", data_ready, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push1(8'(i * 3 + 1));
    chk("R5 full", level, 16);
    chk("R5 no overrun yet", overrun, 0);
    push1(8'hEE);
    chk("R5 overrun set", overrun, 1);
    chk("R5 level kept", level, 16);
    chk("R5 head intact", rd_data, 1);
    lsr1();
    chk("R5 overrun cleared by status read", overrun, 0);
    push_valid = 1; push_data = 8'h77; pop = 1;
    cyc();
    push_valid = 0; pop = 0;
    chk("R11 level stays 16", level, 16);
    chk("R11 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R5 stored order", rd_data, i * 3 + 1);
      pop1();
    end
    chk("R11 swapped-in byte last", rd_data, 8'h77);
    pop1();
    chk("R5 drained", level, 0);
  endtask

  task automatic t_underflow();
    pop1();
    chk("R6 empty pop level", level, 0);
    chk("R6 empty pop data_ready", data_ready, 0);
    push1(8'h3C);
    chk("R6 later push level", level, 1);
    chk("R6 later push data", rd_data, 8'h3C);
    pop1();
  endtask

  task automatic t_tags();
    push1(8'h11, 1, 0, 0);
    push1(8'h22);
    push1(8'h33, 0, 1, 1);
    chk("R7 head perr", head_perr, 1);
    chk("R7 head ferr/brk clear", {head_ferr, head_brk}, 0);
    chk("R8 err_any", err_any, 1);
    lsr1();
    chk("R7 tag hidden after read", head_perr, 0);
    chk("R8 err_any still set", err_any, 1);
    pop1();
    chk("R7 clean head", {head_perr, head_ferr, head_brk}, 0);
    chk("R8 tagged entry behind", err_any, 1);
    pop1();
    chk("R7 new head tags", {head_perr, head_ferr, head_brk}, 3'b011);
    pop1();
    chk("R8 err_any clear", err_any, 0);
    push1(8'h44, 0, 0, 1);
    fcr1(8'h02);
    chk("R4 clear drops err_any", err_any, 0);
  endtask

  task automatic t_timeout();
    tick1(); tick1(); tick1(); tick1(); tick1();
    chk("R9 no timeout when empty", timeout, 0);
    push1(8'h54);
    tick1(); tick1(); tick1();
    chk("R9 three ticks", timeout, 0);
    push1(8'h55);
    tick1(); tick1(); tick1();
    chk("R9 push restarted", timeout, 0);
    tick1();
    chk("R9 fourth tick", timeout, 1);
    pop1();
    chk("R9 pop clears", timeout, 0);
    chk("R9 one left", rd_data, 8'h55);
    tick1(); tick1(); tick1(); tick1();
    chk("R9 timeout again", timeout, 1);
    pop1();
    chk("R10 data_ready clear", data_ready, 0);
    chk("R10 timeout clear", timeout, 0);
  endtask

  initial begin
    rst_n = 0;
    push_valid = 0; push_data = 0; push_perr = 0; push_ferr = 0; push_brk = 0;
    pop = 0; lsr_rd = 0; fcr_we = 0; fcr_data = 0; char_tick = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    t_reset();
    t_order();
    t_trigger();
    t_overrun();
    t_underflow();
    t_tags();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule